// File: doc/BRIEF.md
# Byte-Serial Microcode Sequencer

This block steps a microcoded processor through its control store. The store is a byte-wide memory, and each 32-bit microword takes up four neighbouring bytes. For every micro-step the sequencer puts out four byte addresses on consecutive cycles. It collects the returned bytes into a microword register, starting with the least significant byte. In the fifth cycle it presents the finished word to the datapath together with a one-cycle valid strobe. At the end of that cycle it works out the next micro-step.

The control-store address is the concatenation of an opcode field, a 5-bit micro-step and a 2-bit byte lane, so each opcode owns a block of 32 microwords. Opcode slot 0 holds the instruction fetch routine. While the fetch flag is up, the opcode field is forced to zero. The fetch routine loads the instruction register from the datapath's memory byte. A fetch word with its fetch bit clear then hands control to step 0 of the freshly loaded opcode's routine. A word with the end bit set sends the sequencer back to fetch. Words can also branch inside their routine, either always or when one of the zero, carry or sign flags is set or clear.

Top module: `useq_sequencer`

## Requirements
- R1: The control-store address is {opcode field (8 bits), micro-step (5 bits), byte lane (2 bits)}, giving 15 bits. The micro-step part changes only at the end of an execute cycle.
- R2: Every microword takes five cycles. Lanes 0, 1, 2 and 3 are addressed in that order on the first four cycles, and the byte read in lane k becomes bits [8k+7:8k] of the microword.
- R3: `uwordValid` is high only on the fifth cycle of each microword, for exactly one cycle. On that cycle `uword` holds all four captured bytes.
- R4: While `inhibit` is high, the opcode field of the address is zero. While it is low, the field equals the instruction register shown on `opcode`.
- R5: When an executed word has bit 29 (instruction load) set, the instruction register takes the value of `instrIn`.
- R6: When a word whose bit 30 (fetch flag) is clear is executed while `inhibit` is high, `inhibit` drops and the next micro-step is 0 of the loaded opcode.
- R7: When a word whose bit 31 (end) is set is executed, the micro-step returns to 0 and `inhibit` rises. This takes priority over every other step rule.
- R8: If no other rule applies, the micro-step increases by one after each executed word and wraps from 31 to 0.
- R9: Bits [28:26] choose a branch condition: 0 never, 1 zero, 2 not zero, 3 carry, 4 not carry, 5 sign, 6 not sign, 7 always. When the condition holds in the execute cycle, the micro-step loads bits [25:21].
- R10: Bit 30 of a word executed while `inhibit` is low has no effect, and the routine continues under the same opcode.
- R11: A synchronous reset clears the micro-step, the byte lane, the microword register and the instruction register, and raises `inhibit`. This holds even in the middle of a microword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csData | input | 8 | Control-store byte for the current address, valid in the same cycle |
| instrIn | input | 8 | Instruction byte from the datapath, loaded on instruction-load words |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagS | input | 1 | Sign flag |
| csAddr | output | 15 | Control-store byte address |
| uword | output | 32 | Assembled microword |
| uwordValid | output | 1 | One-cycle strobe: the microword is complete and executing |
| inhibit | output | 1 | High while the fetch routine runs from slot 0 |
| microStep | output | 5 | Current micro-step |
| opcode | output | 8 | Instruction register |

## Verification
The checker assumes the control store answers in the same cycle as the address, as an asynchronous read. It also assumes that `instrIn` and the flags are steady across the execute cycle, because they are sampled only at its closing edge. The bench models the store as a sparse function of the address and sets the flags and instruction byte only while a word's bytes are being read, never at a clock edge. Reset is raised once in the middle of a microword, so the checker's properties are exercised across a broken-off sequence.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int BYTE_W   = 8;
  localparam int LANE_W   = 2;
  localparam int LANES    = 1 << LANE_W;
  localparam int WORD_W   = BYTE_W * LANES;
  localparam int STEP_W   = 5;
  localparam int OP_W     = 8;
  localparam int ADDR_W   = OP_W + STEP_W + LANE_W;
  localparam int COND_W   = 3;
  localparam int END_BIT  = WORD_W - 1;
  localparam int FETCH_BIT = WORD_W - 2;
  localparam int LDI_BIT  = WORD_W - 3;
  localparam int COND_LSB = LDI_BIT - COND_W;
  localparam int TGT_LSB  = COND_LSB - STEP_W;

  typedef enum logic [COND_W-1:0] {
    CondNone     = 3'd0,
    CondZero     = 3'd1,
    CondNotZero  = 3'd2,
    CondCarry    = 3'd3,
    CondNotCarry = 3'd4,
    CondSign     = 3'd5,
    CondNotSign  = 3'd6,
    CondAlways   = 3'd7
  } cond_e;

  // strobes from the phase control into the datapath
  typedef struct packed {
    logic              capture;
    logic [LANE_W-1:0] lane;
    logic              execute;
  } seqStrobe_t;
endpackage

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl
  import useq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output seqStrobe_t strobe
);
  // phases 0..LANES-1 read bytes, phase LANES executes
  localparam int PH_W = $clog2(LANES + 1);
  localparam logic [PH_W-1:0] EXEC_PH = PH_W'(LANES);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)                  phase <= '0;
    else if (phase == EXEC_PH) phase <= '0;
    else                      phase <= phase + PH_W'(1);
  end

  always_comb begin
    strobe.execute = (phase == EXEC_PH);
    strobe.capture = (phase != EXEC_PH);
    strobe.lane    = phase[LANE_W-1:0];
  end
endmodule

// File: rtl/useq_dp.sv
`timescale 1ns/1ps
module useq_dp
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [BYTE_W-1:0] csData,
  input  logic [OP_W-1:0]   instrIn,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagS,
  output logic [ADDR_W-1:0] csAddr,
  output logic [WORD_W-1:0] uword,
  output logic              inhibit,
  output logic [STEP_W-1:0] microStep,
  output logic [OP_W-1:0]   opcode
);
  logic [WORD_W-1:0] wordBus;

  // one byte register per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (rst)
        laneQ <= '0;
      else if (strobe.capture && strobe.lane == LANE_W'(g))
        laneQ <= csData;
    end
    assign wordBus[g*BYTE_W +: BYTE_W] = laneQ;
  end

  function automatic logic condHit(cond_e c, logic z, logic cy, logic s);
    case (c)
      CondZero:     return z;
      CondNotZero:  return !z;
      CondCarry:    return cy;
      CondNotCarry: return !cy;
      CondSign:     return s;
      CondNotSign:  return !s;
      CondAlways:   return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

  logic              endBit, fetchBit, ldiBit, taken;
  logic [STEP_W-1:0] target;
  logic [STEP_W-1:0] stepQ;
  logic              inhibitQ;
  logic [OP_W-1:0]   irQ;

  always_comb begin
    endBit   = wordBus[END_BIT];
    fetchBit = wordBus[FETCH_BIT];
    ldiBit   = wordBus[LDI_BIT];
    target   = wordBus[TGT_LSB +: STEP_W];
    taken    = condHit(cond_e'(wordBus[COND_LSB +: COND_W]), flagZ, flagC, flagS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepQ    <= '0;
      inhibitQ <= 1'b1;
      irQ      <= '0;
    end else if (strobe.execute) begin
      if (ldiBit) irQ <= instrIn;
      if (endBit) begin
        stepQ    <= '0;
        inhibitQ <= 1'b1;
      end else if (inhibitQ && !fetchBit) begin
        stepQ    <= '0;
        inhibitQ <= 1'b0;
      end else if (taken) begin
        stepQ <= target;
      end else begin
        stepQ <= stepQ + STEP_W'(1);
      end
    end
  end

  always_comb begin
    csAddr    = {(inhibitQ ? {OP_W{1'b0}} : irQ), stepQ, strobe.lane};
    uword     = wordBus;
    inhibit   = inhibitQ;
    microStep = stepQ;
    opcode    = irQ;
  end
endmodule

// File: rtl/useq_sequencer.sv
`timescale 1ns/1ps
module useq_sequencer
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] csData,
  input  logic [OP_W-1:0]   instrIn,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagS,
  output logic [ADDR_W-1:0] csAddr,
  output logic [WORD_W-1:0] uword,
  output logic              uwordValid,
  output logic              inhibit,
  output logic [STEP_W-1:0] microStep,
  output logic [OP_W-1:0]   opcode
);
  seqStrobe_t strobe;

  useq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  useq_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .csData    (csData),
    .instrIn   (instrIn),
    .flagZ     (flagZ),
    .flagC     (flagC),
    .flagS     (flagS),
    .csAddr    (csAddr),
    .uword     (uword),
    .inhibit   (inhibit),
    .microStep (microStep),
    .opcode    (opcode)
  );

  assign uwordValid = strobe.execute;
endmodule

// File: rtl/useq_checker.sv
`timescale 1ns/1ps
module useq_checker
  import useq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] csAddr,
  input logic [WORD_W-1:0] uword,
  input logic              uwordValid,
  input logic              inhibit,
  input logic [STEP_W-1:0] microStep,
  input logic [OP_W-1:0]   opcode
);
  p_step_in_addr_r1: assert property (@(posedge clk) disable iff (rst)
    csAddr[LANE_W +: STEP_W] == microStep);

  p_step_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !uwordValid |=> $stable(microStep));

  p_last_lane_r2: assert property (@(posedge clk) disable iff (rst)
    (!uwordValid && csAddr[LANE_W-1:0] == LANE_W'(LANES-1)) |=> uwordValid);

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    uwordValid |=> !uwordValid);

  p_fetch_slot_r4: assert property (@(posedge clk) disable iff (rst)
    inhibit |-> csAddr[ADDR_W-1 -: OP_W] == '0);

  p_ir_slot_r4: assert property (@(posedge clk) disable iff (rst)
    !inhibit |-> csAddr[ADDR_W-1 -: OP_W] == opcode);

  p_end_word_r7: assert property (@(posedge clk) disable iff (rst)
    (uwordValid && uword[END_BIT]) |=> (inhibit && microStep == '0));

  p_inhibit_kept_r10: assert property (@(posedge clk) disable iff (rst)
    (uwordValid && !inhibit && !uword[END_BIT]) |=> !inhibit);
endmodule

bind useq_sequencer useq_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .csAddr     (csAddr),
  .uword      (uword),
  .uwordValid (uwordValid),
  .inhibit    (inhibit),
  .microStep  (microStep),
  .opcode     (opcode)
);

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  csData;
  logic [7:0]  instrIn = 8'h00;
  logic        flagZ = 1'b0;
  logic        flagC = 1'b0;
  logic        flagS = 1'b0;
  logic [14:0] csAddr;
  logic [31:0] uword;
  logic        uwordValid;
  logic        inhibit;
  logic [4:0]  microStep;
  logic [7:0]  opcode;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  useq_sequencer dut (
    .clk(clk), .rst(rst), .csData(csData), .instrIn(instrIn),
    .flagZ(flagZ), .flagC(flagC), .flagS(flagS),
    .csAddr(csAddr), .uword(uword), .uwordValid(uwordValid),
    .inhibit(inhibit), .microStep(microStep), .opcode(opcode)
  );

  // word layout: end[31] fetch[30] load[29] cond[28:26] target[25:21] data[20:0]
  function automatic logic [31:0] mk(bit e, bit f, bit l, logic [2:0] c,
                                     logic [4:0] t, logic [20:0] d);
    return {e, f, l, c, t, d};
  endfunction

  function automatic logic [31:0] romWord(logic [7:0] op, logic [4:0] st);
    case ({op, st})
      {8'h00, 5'd0}:  return mk(0, 1, 1, 3'd0, 5'd0,  21'h01001);
      {8'h00, 5'd1}:  return mk(0, 0, 0, 3'd0, 5'd0,  21'h00002);
      {8'h31, 5'd0}:  return mk(0, 0, 0, 3'd1, 5'd5,  21'h031AA);
      {8'h31, 5'd1}:  return mk(0, 1, 0, 3'd0, 5'd0,  21'h00011);
      {8'h31, 5'd2}:  return mk(1, 0, 0, 3'd0, 5'd0,  21'h00022);
      {8'h31, 5'd5}:  return mk(1, 0, 0, 3'd0, 5'd0,  21'h00055);
      {8'h3C, 5'd0}:  return mk(0, 0, 0, 3'd5, 5'd31, 21'h03C00);
      {8'h3C, 5'd1}:  return mk(1, 0, 0, 3'd0, 5'd0,  21'h03C01);
      {8'h3C, 5'd31}: return mk(0, 0, 0, 3'd0, 5'd0,  21'h03C1F);
      {8'h34, 5'd0}:  return mk(0, 0, 0, 3'd4, 5'd7,  21'h03400);
      {8'h34, 5'd7}:  return mk(1, 0, 0, 3'd0, 5'd0,  21'h03407);
      default:        return 32'h0;
    endcase
  endfunction

  always_comb begin
    logic [31:0] w;
    w = romWord(csAddr[14:7], csAddr[6:2]);
    csData = w[8*csAddr[1:0] +: 8];
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  // one full microword, entered on the negedge of its lane-0 cycle
  task automatic runWord(logic [7:0] op, logic [4:0] st, string req);
    logic [31:0] w;
    w = romWord(op, st);
    for (int k = 0; k < 4; k++) begin
      chk(csAddr == {op, st, k[1:0]}, req, "R1 byte address", 32'(csAddr), 32'({op, st, k[1:0]}));
      chk(!uwordValid, "R3", "valid during read", 32'(uwordValid), 32'd0);
      @(negedge clk);
    end
    chk(uwordValid, "R3", "valid strobe", 32'(uwordValid), 32'd1);
    chk(uword == w, "R2", "assembled word", uword, w);
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk); @(negedge clk);
    chk(csAddr == 15'd0, "R11", "reset address", 32'(csAddr), 32'd0);
    chk(inhibit, "R11", "reset inhibit", 32'(inhibit), 32'd1);
    chk(uword == 32'd0 && !uwordValid, "R11", "reset word", uword, 32'd0);
    chk(microStep == 5'd0 && opcode == 8'd0, "R11", "reset step/ir",
        32'({microStep, opcode}), 32'd0);
    rst = 1'b0;
  endtask

  task automatic testFetch(logic [7:0] ins);
    instrIn = ins;
    runWord(8'h00, 5'd0, "R4");
    chk(opcode == ins, "R5", "instruction load", 32'(opcode), 32'(ins));
    chk(inhibit, "R6", "still fetching", 32'(inhibit), 32'd1);
    runWord(8'h00, 5'd1, "R4");
    chk(!inhibit && microStep == 5'd0, "R6", "handoff", 32'({inhibit, microStep}), 32'd0);
  endtask

  task automatic testBranchZeroTaken();
    flagZ = 1'b1;
    testFetch(8'h31);
    runWord(8'h31, 5'd0, "R9");
    chk(microStep == 5'd5, "R9", "zero taken", 32'(microStep), 32'd5);
    runWord(8'h31, 5'd5, "R7");
    chk(inhibit && microStep == 5'd0, "R7", "end returns", 32'({inhibit, microStep}), 32'h20);
  endtask

  task automatic testBranchZeroNotTaken();
    flagZ = 1'b0;
    testFetch(8'h31);   // IR already 31: slot 0 address proves field forced to 0 (R4)
    runWord(8'h31, 5'd0, "R9");
    chk(microStep == 5'd1, "R8", "not taken increments", 32'(microStep), 32'd1);
    runWord(8'h31, 5'd1, "R10");
    chk(!inhibit && microStep == 5'd2, "R10", "fetch bit ignored", 32'({inhibit, microStep}), 32'd2);
    runWord(8'h31, 5'd2, "R7");
  endtask

  task automatic testSignWrap();
    flagS = 1'b1;
    testFetch(8'h3C);
    runWord(8'h3C, 5'd0, "R9");
    chk(microStep == 5'd31, "R9", "sign taken", 32'(microStep), 32'd31);
    flagS = 1'b0;
    runWord(8'h3C, 5'd31, "R8");
    chk(microStep == 5'd0 && !inhibit, "R8", "wrap 31 to 0", 32'({inhibit, microStep}), 32'd0);
    runWord(8'h3C, 5'd0, "R9");
    chk(microStep == 5'd1, "R9", "sign clear not taken", 32'(microStep), 32'd1);
    runWord(8'h3C, 5'd1, "R7");
  endtask

  task automatic testNotCarry();
    flagC = 1'b0;
    testFetch(8'h34);
    runWord(8'h34, 5'd0, "R9");
    chk(microStep == 5'd7, "R9", "not carry taken", 32'(microStep), 32'd7);
    runWord(8'h34, 5'd7, "R7");
  endtask

  task automatic testMidReset();
    flagC = 1'b1;
    testFetch(8'h34);
    @(negedge clk); @(negedge clk);   // lanes 0 and 1 of op 34 step 0 captured
    chk(uword == 32'h00003400, "R2", "partial word", uword, 32'h00003400);
    rst = 1'b1;
    @(negedge clk);
    chk(csAddr == 15'd0 && inhibit, "R11", "mid reset address", 32'({inhibit, csAddr}), 32'h8000);
    chk(uword == 32'd0 && microStep == 5'd0 && opcode == 8'd0, "R11", "mid reset state",
        uword, 32'd0);
    rst = 1'b0;
    testFetch(8'h3C);
  endtask

  initial begin
    testReset();
    testBranchZeroTaken();
    testBranchZeroNotTaken();
    testSignWrap();
    testNotCarry();
    testMidReset();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule